// File: doc/BRIEF.md
# Banked Bit-Line Select Mux and Clearing Demux

This block divides a memory's data bit lines into four banks. On the write side a demultiplexer sends the write word to the one bank chosen by the select. It drives the other three bank outputs to the clear state, which is all zeros. On the read side a multiplexer passes the chosen bank's read word to a single output. That result is only meaningful when every bank that was not chosen presents a clear word. The block checks that condition and flags any breach.

The bank number comes from the two most significant address bits. It is captured at the start of a six-phase operation. A second, delayed copy of the bank number is kept and used when a transfer is released. The caller steps a phase input through 0 to 5:
- the write side acts in phases 2 and 3;
- the read side acts in phases 4 and 5.

Phase values 6 and 7 mean idle. A sticky flag records any change of the address's bank bits while a transfer is in flight.

Top module: `bank_bitline_mux`

## Requirements
- R1: While reset is low, and in the first cycle after it, every bank write output, the read output and both flags are zero.
- R2: At a clock edge where phase is 0, the bank number is taken from the two most significant bits of `addr`; the other address bits have no effect on which bank is used.
- R3: At a clock edge where phase is 2, bank b's slice of `wr_bank` (bits b*DATA_W upward) takes `wr_data` when b is the captured bank, and every other slice takes zero; at most one slice is ever non-zero.
- R4: At a clock edge where phase is 3, the slice named by the delayed bank copy is released to zero, so all of `wr_bank` is zero afterwards.
- R5: At a clock edge where phase is 4, `rd_data` takes the `rd_bank` slice of the captured bank, whether or not other slices are clear.
- R6: At a clock edge where phase is 4, `clear_err` is set to 1 if any slice of `rd_bank` other than the captured bank's is non-zero, and to 0 otherwise.
- R7: At a clock edge where phase is 5, `rd_data` and `clear_err` return to zero.
- R8: At a clock edge where phase is 1 to 5 and the two top bits of `addr` differ from the captured bank, `sel_err` becomes 1 and stays 1 until reset.
- R9: At a clock edge where phase is 6 or 7, no output and no captured state changes, whatever `addr`, `wr_data` and `rd_bank` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase | input | 3 | Operation phase, 0 to 5; 6 and 7 are idle |
| addr | input | ADDR_W | Address; the top two bits choose the bank |
| wr_data | input | DATA_W | Write word |
| wr_bank | output | 4*DATA_W | Per-bank write bit lines |
| rd_bank | input | 4*DATA_W | Per-bank read bit lines |
| rd_data | output | DATA_W | Selected read word |
| clear_err | output | 1 | An unselected read bank was not clear |
| sel_err | output | 1 | Bank bits changed during a transfer (sticky) |

## Verification
Every result is registered once, so it appears in the cycle after the edge that sampled the phase that causes it:
- the demux word is visible while phase 3 is presented, and is gone while phase 4 is presented;
- the mux word and the clear flag are visible while phase 5 is presented, and are gone one cycle later.

The bench drives inputs on the falling edge. Before it drives the next phase, it checks the outputs produced by the rising edge just passed, so each comparison lands exactly in the cycle the result is due. The bench sweeps all four banks under several data words, with and without a dirty neighbour bank. It also covers idle phases and a bank change in mid-transfer.

// File: rtl/bank_bitline_mux.sv
module bank_bitline_mux #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int SEL_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    phase,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [(1<<SEL_W)*DATA_W-1:0]  wr_bank,
  input  logic [(1<<SEL_W)*DATA_W-1:0]  rd_bank,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          clear_err,
  output logic                          sel_err
);
  localparam int NB = 1 << SEL_W;

  logic [SEL_W-1:0] bank_q, bank_d;
  logic [SEL_W-1:0] live_bank;
  logic [NB-1:0]    rd_nz, wr_nz, sel_mask;
  logic             dirty;

  assign live_bank = addr[ADDR_W-1 -: SEL_W];
  assign sel_mask  = NB'(1) << bank_q;
  assign dirty     = |(rd_nz & ~sel_mask);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign rd_nz[b] = |rd_bank[b*DATA_W +: DATA_W];
    assign wr_nz[b] = |wr_bank[b*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q    <= '0;
      bank_d    <= '0;
      wr_bank   <= '0;
      rd_data   <= '0;
      clear_err <= 1'b0;
    end else begin
      case (phase)
        3'd0: bank_q <= live_bank;
        3'd1: bank_d <= bank_q;
        3'd2: for (int b = 0; b < NB; b++)
                wr_bank[b*DATA_W +: DATA_W] <= (bank_q == SEL_W'(b)) ? wr_data : '0;
        3'd3: wr_bank[int'(bank_d)*DATA_W +: DATA_W] <= '0;
        3'd4: begin
          rd_data   <= rd_bank[int'(bank_q)*DATA_W +: DATA_W];
          clear_err <= dirty;
        end
        3'd5: begin
          rd_data   <= '0;
          clear_err <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sel_err <= 1'b0;
    else if (phase >= 3'd1 && phase <= 3'd5 && live_bank != bank_q)
      sel_err <= 1'b1;
  end

  AST_DEMUX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_nz) <= 1); // R3
  AST_WR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd3 |=> wr_bank == '0); // R4
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd5 |=> (rd_data == '0 && !clear_err)); // R7
  AST_SEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |=> sel_err); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    phase > 3'd5 |=> ($stable(wr_bank) && $stable(rd_data) && $stable(clear_err))); // R9
endmodule

// File: tb/tb_bank_bitline_mux.sv
module tb_bank_bitline_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  phase = 3'd6;
  logic [5:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [31:0] wr_bank;
  logic [31:0] rd_bank = '0;
  logic [7:0]  rd_data;
  logic        clear_err, sel_err;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bank_bitline_mux dut (
    .clk(clk), .rst_n(rst_n), .phase(phase), .addr(addr), .wr_data(wr_data),
    .wr_bank(wr_bank), .rd_bank(rd_bank), .rd_data(rd_data),
    .clear_err(clear_err), .sel_err(sel_err));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input int bk, input logic [7:0] wd, input logic [31:0] rdv,
                        input bit move_bank);
    logic [31:0] exp_wr;
    logic [7:0]  exp_rd;
    bit          exp_dirty;
    exp_wr = 32'(wd) << (bk*8);
    exp_rd = rdv[bk*8 +: 8];
    exp_dirty = 0;
    for (int b = 0; b < 4; b++) if (b != bk && rdv[b*8 +: 8] != 0) exp_dirty = 1;
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      if (p == 3) check("R3 R2 demux", wr_bank, exp_wr);
      if (p == 4) check("R4 write release", wr_bank, 32'd0);
      if (p == 5) begin
        check("R5 mux", 32'(rd_data), 32'(exp_rd));
        check("R6 clear flag", 32'(clear_err), 32'(exp_dirty));
      end
      phase = 3'(p);
      if (p == 0) addr = {2'(bk), 4'(wd ^ 8'h3C)};
      if (p == 2) begin
        wr_data = wd;
        if (move_bank) addr = {2'(bk + 1), addr[3:0]};
      end
      if (p == 4) rd_bank = rdv;
    end
    @(negedge clk);
    check("R7 read release", {23'd0, clear_err, rd_data}, 32'd0);
    phase = 3'd6;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [3];
    logic [31:0] rdv;
    pats[0] = 8'hA5; pats[1] = 8'hFF; pats[2] = 8'h01;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {wr_bank[23:0], rd_data}, 32'd0);
    check("R1 reset flags", {30'd0, clear_err, sel_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", wr_bank, 32'd0);

    for (int bk = 0; bk < 4; bk++)
      for (int k = 0; k < 3; k++) begin
        rdv = 32'(pats[k] ^ 8'h5A) << (bk*8);
        run_op(bk, pats[k], rdv, 0);
        rdv[((bk + 1 + k) % 4)*8 +: 8] = 8'h80 >> k;
        run_op(bk, pats[k], rdv, 0);
      end
    check("R8 no bank change", 32'(sel_err), 32'd0);

    run_op(2, 8'h77, 32'h0011_0000, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      phase = (i % 2 == 0) ? 3'd6 : 3'd7;
      addr = 6'(i * 13);
      wr_data = 8'(i * 29 + 1);
      rd_bank = 32'hDEAD_BEEF + 32'(i);
    end
    @(negedge clk);
    check("R9 idle wr", wr_bank, 32'd0);
    check("R9 idle rd", {23'd0, clear_err, rd_data}, 32'd0);
    check("R9 idle sel_err", 32'(sel_err), 32'd0);

    run_op(1, 8'h3E, 32'h0000_4200, 1);
    check("R8 bank change flagged", 32'(sel_err), 32'd1);
    repeat (3) @(negedge clk);
    check("R8 sticky", 32'(sel_err), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 R1 reset clears", 32'(sel_err), 32'd0);
    rst_n = 1'b1;
    run_op(3, 8'h9C, 32'h6600_0000, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule